// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing datapath. Each accepted command names an operation, one of two 40-bit accumulators (A or B) as its target, and two 16-bit operands. A shared 17x17 multiplier forms either the product of the operands or the square of their difference. The operands may be treated as signed or unsigned, and the product may be kept as an integer or aligned as a fraction. A 41-bit add/subtract stage then combines the term with the target or with the other accumulator. Optional saturation clamps the result before it is written back.

Commands arrive on a valid/ready stream. `in_ready` is low while `rst` is high and stays high after that, so the block never applies back-pressure once running. A command is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result is visible on `acc_a`/`acc_b` and the flags one cycle later. The mode pins are sampled on the same edge. Separately, a combinational readout rounds the accumulator chosen by `rd_sel` to a 16-bit word and can clamp that word.

Top module: `dsp_mac_engine`

## Requirements
- R1: `in_ready` is 0 while `rst` is high and 1 afterwards. A command changes state only on an edge where `in_valid` and `in_ready` are both 1. When `in_valid` is 0, the accumulators and flags hold.
- R2: Reset clears both accumulators, `acc_ov` and `acc_sat`.
- R3: The `in_op` codes act on target T, with P the product term and D the squared-difference term. 0 clears T. 1 sets T=D. 2 sets T=T+D. 3 sets T=T+P. 4 sets T=T-P. 5 sets T=P. 6 sets T=-P. 7 leaves all state unchanged. Codes 11 to 15 behave as 7.
- R4: The operand-free codes use O, the other accumulator. 8 sets T=T+O, 9 sets T=T-O and 10 sets T=-T.
- R5: With `cfg_unsigned`=1 the operands are zero-extended to 17 bits, otherwise they are sign-extended. D squares the 17-bit signed difference of the extended operands.
- R6: With `cfg_frac`=1 the term is the product shifted left by one bit. With `cfg_frac`=0 the term is the plain product. In both cases the term is sign-extended to 40 bits.
- R7: If saturation is enabled for the target (`sat_en_a` for `in_sel`=0, `sat_en_b` for `in_sel`=1) and `sat_wide`=0, the result is clamped to the range 0xFF80000000 to 0x007FFFFFFF. If saturation is disabled for the target, the result wraps to 40 bits.
- R8: With saturation enabled and `sat_wide`=1, only a result beyond the 40-bit signed range is clamped, to 0x7FFFFFFFFF or 0x8000000000.
- R9: On each write, the target's flag in `acc_ov` (bit 0 = A, bit 1 = B) is set if the unclamped result lies outside the 32-bit signed range. The target's `acc_sat` bit is set if clamping was applied. Both bits are cleared otherwise.
- R10: `rd_data` is bits 31:16 of the selected accumulator, rounded using the low 16 bits. With `rnd_convergent`=0 it is rounded up when the low word is at least 0x8000. With `rnd_convergent`=1 it is rounded up when the low word is above 0x8000, or when it equals 0x8000 and bit 16 is 1.
- R11: With `rd_sat_en`=1, a rounded value outside the signed 16-bit range reads as 0x7FFF or 0x8000. With `rd_sat_en`=0 it reads as its low 16 bits.
- R12: A command never changes the accumulator it does not target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command can be taken |
| in_op | input | 4 | Operation code |
| in_sel | input | 1 | Target: 0 = A, 1 = B |
| in_x | input | 16 | First operand |
| in_y | input | 16 | Second operand |
| cfg_frac | input | 1 | Fractional product alignment |
| cfg_unsigned | input | 1 | Unsigned operands |
| sat_en_a | input | 1 | Saturation on for A |
| sat_en_b | input | 1 | Saturation on for B |
| sat_wide | input | 1 | Saturation at 40-bit limits |
| rnd_convergent | input | 1 | Readout rounding: 1 = convergent |
| rd_sat_en | input | 1 | Readout clamps to 16 bits |
| rd_sel | input | 1 | Readout source: 0 = A, 1 = B |
| rd_data | output | 16 | Rounded readout word |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| acc_ov | output | 2 | 32-bit overflow flag per accumulator |
| acc_sat | output | 2 | Clamp-applied flag per accumulator |

## Verification
Rounding and readout clamping can both act on the same `rd_data` value. An accumulator near the positive 32-bit limit with a low word above one half carries into a word that no longer fits in 16 bits. The bench saturates A to 0x007FFFFFFF and reads it with `rd_sat_en` both high and low. It expects 0x7FFF and 0x8000 respectively. A second overlap, between the overflow flag and the clamp flag on one write, is provoked by a fractional square of the most negative operand. That write is checked once with saturation off and once with it on.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;
  typedef enum logic [3:0] {
    OP_CLR    = 4'd0,
    OP_ED     = 4'd1,
    OP_EDAC   = 4'd2,
    OP_MAC    = 4'd3,
    OP_MSC    = 4'd4,
    OP_MPY    = 4'd5,
    OP_MPYN   = 4'd6,
    OP_HOLD   = 4'd7,
    OP_ADD    = 4'd8,
    OP_SUB    = 4'd9,
    OP_NEG    = 4'd10
  } dsp_op_e;
endpackage

// File: rtl/dsp_mac_mult.sv
module dsp_mac_mult #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              is_unsigned,
  input  logic              frac,
  input  logic              square,
  output logic [ACC_W-1:0]  term
);
  localparam int MW = DATA_W + 1;
  localparam int PW = 2 * MW;
  localparam int AW = PW + 1;

  logic signed [MW-1:0] ext_x, ext_y, diff, opa, opb;
  logic signed [PW-1:0] prod;
  logic [AW-1:0]        aligned;

  always_comb begin
    ext_x   = is_unsigned ? {1'b0, x} : {x[DATA_W-1], x};
    ext_y   = is_unsigned ? {1'b0, y} : {y[DATA_W-1], y};
    diff    = ext_x - ext_y;
    opa     = square ? diff : ext_x;
    opb     = square ? diff : ext_y;
    prod    = opa * opb;
    aligned = frac ? {prod, 1'b0} : {prod[PW-1], prod};
    term    = {{(ACC_W-AW){aligned[AW-1]}}, aligned};
  end
endmodule

// File: rtl/dsp_mac_addsat.sv
module dsp_mac_addsat #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [ACC_W-1:0] base,
  input  logic [ACC_W-1:0] addend,
  input  logic             negate,
  input  logic             sat_en,
  input  logic             sat_wide,
  output logic [ACC_W-1:0] result,
  output logic             ov32,
  output logic             clamped
);
  localparam int SW = ACC_W + 1;
  localparam logic signed [SW-1:0] NPOS = {{(SW-2*DATA_W+1){1'b0}}, {(2*DATA_W-1){1'b1}}};
  localparam logic signed [SW-1:0] NNEG = ~NPOS;
  localparam logic signed [SW-1:0] WPOS = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [SW-1:0] WNEG = ~WPOS;

  logic signed [SW-1:0] eb, ea, sum, hi, lo;

  always_comb begin
    eb      = {base[ACC_W-1], base};
    ea      = {addend[ACC_W-1], addend};
    sum     = negate ? eb - ea : eb + ea;
    hi      = sat_wide ? WPOS : NPOS;
    lo      = sat_wide ? WNEG : NNEG;
    ov32    = (sum > NPOS) || (sum < NNEG);
    clamped = 1'b0;
    result  = sum[ACC_W-1:0];
    if (sat_en && sum > hi) begin
      result  = hi[ACC_W-1:0];
      clamped = 1'b1;
    end else if (sat_en && sum < lo) begin
      result  = lo[ACC_W-1:0];
      clamped = 1'b1;
    end
  end
endmodule

// File: rtl/dsp_mac_round.sv
module dsp_mac_round #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic              convergent,
  input  logic              clamp,
  output logic [DATA_W-1:0] word
);
  localparam int HW = ACC_W - DATA_W;
  localparam logic [DATA_W-1:0]  HALF = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [HW:0] PLIM = {{(HW-DATA_W+2){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [HW:0] NLIM = ~PLIM;

  logic [HW-1:0]     hi;
  logic [DATA_W-1:0] lo;
  logic              inc;
  logic signed [HW:0] r;

  always_comb begin
    hi  = acc[ACC_W-1:DATA_W];
    lo  = acc[DATA_W-1:0];
    inc = convergent ? ((lo > HALF) || (lo == HALF && hi[0])) : lo[DATA_W-1];
    r   = {hi[HW-1], hi} + {{HW{1'b0}}, inc};
    if (clamp && r > PLIM)      word = PLIM[DATA_W-1:0];
    else if (clamp && r < NLIM) word = NLIM[DATA_W-1:0];
    else                        word = r[DATA_W-1:0];
  end
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine
  import dsp_mac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic              in_sel,
  input  logic [DATA_W-1:0] in_x,
  input  logic [DATA_W-1:0] in_y,
  input  logic              cfg_frac,
  input  logic              cfg_unsigned,
  input  logic              sat_en_a,
  input  logic              sat_en_b,
  input  logic              sat_wide,
  input  logic              rnd_convergent,
  input  logic              rd_sat_en,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [ACC_W-1:0]  acc_a,
  output logic [ACC_W-1:0]  acc_b,
  output logic [1:0]        acc_ov,
  output logic [1:0]        acc_sat
);
  localparam int NACC = 2;

  logic [ACC_W-1:0] acc_q [NACC];
  logic [NACC-1:0]  ov_q, sat_q;
  logic             rdy_q;

  dsp_op_e          op;
  logic             fire, writes, square, negate, sat_sel;
  logic [ACC_W-1:0] tgt, oth, base, addend, term, result;
  logic             ov32, clamped;

  assign op   = dsp_op_e'(in_op);
  assign fire = in_valid & rdy_q;
  assign tgt  = acc_q[in_sel];
  assign oth  = acc_q[~in_sel];
  assign sat_sel = in_sel ? sat_en_b : sat_en_a;

  always_comb begin
    writes = 1'b1;
    square = 1'b0;
    negate = 1'b0;
    base   = tgt;
    addend = term;
    unique case (op)
      OP_CLR:  begin base = '0; addend = '0; end
      OP_ED:   begin base = '0; square = 1'b1; end
      OP_EDAC: square = 1'b1;
      OP_MAC:  ;
      OP_MSC:  negate = 1'b1;
      OP_MPY:  base = '0;
      OP_MPYN: begin base = '0; negate = 1'b1; end
      OP_ADD:  addend = oth;
      OP_SUB:  begin addend = oth; negate = 1'b1; end
      OP_NEG:  begin base = '0; addend = tgt; negate = 1'b1; end
      default: writes = 1'b0;
    endcase
  end

  dsp_mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
    .x(in_x), .y(in_y), .is_unsigned(cfg_unsigned), .frac(cfg_frac),
    .square(square), .term(term)
  );

  dsp_mac_addsat #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_addsat (
    .base(base), .addend(addend), .negate(negate), .sat_en(sat_sel),
    .sat_wide(sat_wide), .result(result), .ov32(ov32), .clamped(clamped)
  );

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    logic hit;
    assign hit = fire && writes && (in_sel == 1'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[i] <= '0;
        ov_q[i]  <= 1'b0;
        sat_q[i] <= 1'b0;
      end else if (hit) begin
        acc_q[i] <= result;
        ov_q[i]  <= ov32;
        sat_q[i] <= clamped;
      end
    end
  end

  dsp_mac_round #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_round (
    .acc(acc_q[rd_sel]), .convergent(rnd_convergent), .clamp(rd_sat_en),
    .word(rd_data)
  );

  assign in_ready = rdy_q;
  assign acc_a    = acc_q[0];
  assign acc_b    = acc_q[1];
  assign acc_ov   = ov_q;
  assign acc_sat  = sat_q;
endmodule

// File: rtl/dsp_mac_engine_chk.sv
module dsp_mac_engine_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic             in_sel,
  input logic             sat_en_a,
  input logic             sat_wide,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b
);
  logic fire;
  assign fire = in_valid && in_ready;

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !fire |=> ($stable(acc_a) && $stable(acc_b)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && in_op == 4'd0 && !in_sel) |=> (acc_a == '0));

  assert_hold_op_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && in_op == 4'd7) |=> ($stable(acc_a) && $stable(acc_b)));

  assert_narrow_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && !in_sel && sat_en_a && !sat_wide && in_op <= 4'd10 && in_op != 4'd7)
    |=> ((&acc_a[ACC_W-1:2*DATA_W-1]) || !(|acc_a[ACC_W-1:2*DATA_W-1])));

  assert_other_a_R12: assert property (@(posedge clk) disable iff (rst)
    (fire && in_sel) |=> $stable(acc_a));

  assert_other_b_R12: assert property (@(posedge clk) disable iff (rst)
    (fire && !in_sel) |=> $stable(acc_b));
endmodule

bind dsp_mac_engine dsp_mac_engine_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_sel(in_sel), .sat_en_a(sat_en_a), .sat_wide(sat_wide),
  .acc_a(acc_a), .acc_b(acc_b)
);

// File: tb/dsp_mac_engine_test.sv
module dsp_mac_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_sel = 1'b0;
  logic [15:0] in_x = '0, in_y = '0;
  logic        cfg_frac = 0, cfg_unsigned = 0, sat_en_a = 0, sat_en_b = 0, sat_wide = 0;
  logic        rnd_convergent = 0, rd_sat_en = 0, rd_sel = 0;
  logic [15:0] rd_data;
  logic [39:0] acc_a, acc_b;
  logic [1:0]  acc_ov, acc_sat;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_mac_engine uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sel(in_sel), .in_x(in_x), .in_y(in_y),
    .cfg_frac(cfg_frac), .cfg_unsigned(cfg_unsigned), .sat_en_a(sat_en_a),
    .sat_en_b(sat_en_b), .sat_wide(sat_wide), .rnd_convergent(rnd_convergent),
    .rd_sat_en(rd_sat_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .acc_a(acc_a), .acc_b(acc_b), .acc_ov(acc_ov), .acc_sat(acc_sat)
  );

  // {op, sel, x, y, cfg{frac,uns,sat_a,sat_b,wide}, expected target}
  localparam logic [81:0] VEC [NV] = '{
    {4'd5,  1'b0, 16'h0003, 16'h0004, 5'b00000, 40'h000000000C},
    {4'd3,  1'b0, 16'hFFFE, 16'h0005, 5'b00000, 40'h0000000002},
    {4'd4,  1'b0, 16'h0007, 16'h0007, 5'b00000, 40'hFFFFFFFFD1},
    {4'd5,  1'b1, 16'hFFFF, 16'hFFFF, 5'b01000, 40'h00FFFE0001},
    {4'd6,  1'b1, 16'hFFFF, 16'h0002, 5'b00000, 40'h0000000002},
    {4'd1,  1'b0, 16'h0005, 16'hFFFD, 5'b00000, 40'h0000000040},
    {4'd2,  1'b0, 16'h0000, 16'h0002, 5'b00000, 40'h0000000044},
    {4'd8,  1'b0, 16'h1234, 16'h5678, 5'b00000, 40'h0000000046},
    {4'd9,  1'b1, 16'h0000, 16'h0000, 5'b00000, 40'hFFFFFFFFBC},
    {4'd10, 1'b1, 16'h0000, 16'h0000, 5'b00000, 40'h0000000044},
    {4'd7,  1'b0, 16'h1111, 16'h2222, 5'b00000, 40'h0000000046},
    {4'd5,  1'b0, 16'h4000, 16'h4000, 5'b10000, 40'h0020000000},
    {4'd5,  1'b0, 16'h8000, 16'h8000, 5'b10000, 40'h0080000000},
    {4'd5,  1'b0, 16'h8000, 16'h8000, 5'b10100, 40'h007FFFFFFF},
    {4'd0,  1'b0, 16'h0000, 16'h0000, 5'b00000, 40'h0000000000},
    {4'd1,  1'b0, 16'h0000, 16'hFFFF, 5'b01000, 40'h00FFFE0001}
  };
  localparam string VREQ [NV] = '{"R3", "R3", "R3", "R5", "R3", "R3", "R3", "R4",
                                   "R4", "R4", "R3", "R6", "R7", "R7", "R3", "R5"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic sel, input logic [15:0] x,
                       input logic [15:0] y, input logic [4:0] cfg, input logic valid);
    @(negedge clk);
    in_op = op; in_sel = sel; in_x = x; in_y = y;
    {cfg_frac, cfg_unsigned, sat_en_a, sat_en_b, sat_wide} = cfg;
    in_valid = valid;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    v = 64'hFFFE0001;
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", {63'd0, in_ready}, 64'd0);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1 ready after reset", {63'd0, in_ready}, 64'd1);
    check("R2 acc_a reset", {24'd0, acc_a}, 64'd0);
    check("R2 acc_b reset", {24'd0, acc_b}, 64'd0);
    check("R2 flags reset", {60'd0, acc_ov, acc_sat}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][81:78], VEC[i][77], VEC[i][76:61], VEC[i][60:45], VEC[i][44:40], 1'b1);
      check(VREQ[i], {24'd0, (VEC[i][77] ? acc_b : acc_a)}, {24'd0, VEC[i][39:0]});
    end

    // R1: command presented without valid changes nothing
    issue(4'd5, 1'b0, 16'h0005, 16'h0005, 5'b00000, 1'b0);
    check("R1 idle holds acc_a", {24'd0, acc_a}, 64'h00FFFE0001);

    // R9: overflow without clamp, then with clamp
    issue(4'd5, 1'b0, 16'h8000, 16'h8000, 5'b10000, 1'b1);
    check("R9 ov set no clamp", {62'd0, acc_ov[0], acc_sat[0]}, 64'd2);
    issue(4'd5, 1'b0, 16'h8000, 16'h8000, 5'b10100, 1'b1);
    check("R9 ov and clamp", {62'd0, acc_ov[0], acc_sat[0]}, 64'd3);

    // R11: rounding carry meets readout clamp, A = 0x007FFFFFFF
    rd_sel = 1'b0; rnd_convergent = 1'b0; rd_sat_en = 1'b1; #1;
    check("R11 clamped readout", {48'd0, rd_data}, 64'h7FFF);
    rd_sat_en = 1'b0; #1;
    check("R11 unclamped readout", {48'd0, rd_data}, 64'h8000);

    // R10: exact half, even and odd upper word
    issue(4'd5, 1'b0, 16'h0080, 16'h0100, 5'b00000, 1'b1);
    rnd_convergent = 1'b0; #1;
    check("R10 conventional half", {48'd0, rd_data}, 64'h0001);
    rnd_convergent = 1'b1; #1;
    check("R10 convergent half even", {48'd0, rd_data}, 64'h0000);
    issue(4'd5, 1'b0, 16'h0180, 16'h0100, 5'b00000, 1'b1);
    check("R10 convergent half odd", {48'd0, rd_data}, 64'h0002);
    rnd_convergent = 1'b0; #1;
    check("R10 conventional half odd", {48'd0, rd_data}, 64'h0002);
    rd_sel = 1'b1; #1;
    check("R10 readout of B", {48'd0, rd_data}, 64'h0000);

    // R8: 40-bit limit reached by alternating accumulator sums
    issue(4'd5, 1'b0, 16'hFFFF, 16'hFFFF, 5'b01111, 1'b1);
    issue(4'd5, 1'b1, 16'hFFFF, 16'hFFFF, 5'b01111, 1'b1);
    for (int k = 0; k < 10; k++) issue(4'd8, k[0], 16'h0, 16'h0, 5'b00111, 1'b1);
    check("R8 acc_a below limit", {24'd0, acc_a}, 64'd89 * v);
    check("R8 acc_b wide clamp", {24'd0, acc_b}, 64'h7FFFFFFFFF);
    check("R9 acc_b flags", {62'd0, acc_ov[1], acc_sat[1]}, 64'd3);
    issue(4'd8, 1'b0, 16'h0, 16'h0, 5'b00100, 1'b1);
    check("R7 narrow clamp after wide", {24'd0, acc_a}, 64'h007FFFFFFF);
    check("R12 acc_b untouched", {24'd0, acc_b}, 64'h7FFFFFFFFF);
    issue(4'd10, 1'b1, 16'h0, 16'h0, 5'b00000, 1'b1);
    check("R7 wrap when disabled", {24'd0, acc_b}, 64'h8000000001);
    issue(4'd15, 1'b1, 16'h7, 16'h7, 5'b00000, 1'b1);
    check("R3 unused code holds", {24'd0, acc_b}, 64'h8000000001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule